// File: doc/BRIEF.md
# Duo-binary circular recursive systematic encoder

This block encodes one block of N bit-couples with a single duo-binary recursive systematic constituent code. The encoder is tail-biting, so the trellis ends in the same state it started in. Each input byte is split into four (A,B) couples, starting from the most significant bit. The bytes are stored in an internal couple memory. While they arrive, a zero-state pre-encoding pass runs four trellis steps per byte to find the final state of the block.

When the last byte has been taken in, the block looks up the circulation state from that final state and N mod 7. It then reads the stored couples back in address order, one per clock, starting from the circulation state. For each couple it emits the systematic pair and two parity bits. After the last couple it reports whether the trellis closed on its start state.

A block length N that is a multiple of 7 has no circulation state. For such a block the encoder raises a length error and emits nothing.

Top module: `circ_duo_rsc_enc`

## Requirements
- R1: Couple k of a byte (k = 0..3) takes A from bit 7-2k and B from bit 6-2k. Couple 4m+k of the block therefore comes from byte m, and the MSB of the first byte goes to A.
- R2: A block is N/4 bytes. Its first byte carries `in_first` and the length `blk_n`, its last byte carries `in_last`. N is a multiple of 4 from 32 to MAX_N.
- R3: The state is S = 4*s1 + 2*s2 + s3. Each step computes f = A^B^s1^s3 (feedback 1+D+D^3) and moves to s1'=f, s2'=s1^B, s3'=s2^B. A enters only the first cell, and B enters all three cells.
- R4: The parity bits of a couple are Y = f^s2^s3 (taps 1+D^2+D^3) and W = f^s3, both taken from the state before the step.
- R5: The start state comes from a table indexed by N mod 7 and the final state F of a zero-start pass. The rows list the start state for F = 0..7:
  - mod 1: 0,6,4,2,7,1,3,5
  - mod 2: 0,3,7,4,5,6,2,1
  - mod 3: 0,5,3,6,2,7,1,4
  - mod 4: 0,4,1,5,6,2,7,3
  - mod 5: 0,2,5,7,1,3,4,6
  - mod 6: 0,7,6,1,3,4,5,2
- R6: The output pass emits exactly N couples on consecutive cycles in address order 0..N-1. `out_first` marks couple 0 and `out_last` marks couple N-1.
- R7: When N mod 7 = 0, `err_len` goes high and no couple is emitted. `err_len` stays high until the next block starts.
- R8: After the last couple, `tail_ok` goes high if the final state of the output pass equals its start state. `tail_ok` is cleared when a block starts.
- R9: While a block is being encoded (`busy` high, after the last byte), input bytes are ignored, including any with `in_first`. The output stream is unaffected.
- R10: After reset, `busy`, `out_valid`, `err_len` and `tail_ok` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input byte valid |
| in_first | input | 1 | First byte of a block |
| in_last | input | 1 | Last byte of a block |
| in_byte | input | 8 | Data byte, MSB first |
| blk_n | input | NW | Block length N in couples, sampled with the first byte |
| busy | output | 1 | Block in progress |
| out_valid | output | 1 | Output couple valid |
| out_first | output | 1 | Couple 0 of the block |
| out_last | output | 1 | Couple N-1 of the block |
| out_a | output | 1 | Systematic bit A |
| out_b | output | 1 | Systematic bit B |
| out_y | output | 1 | Parity Y |
| out_w | output | 1 | Parity W |
| err_len | output | 1 | Block length is a multiple of 7 |
| tail_ok | output | 1 | Trellis closed on its start state |

## Verification
The bench sweeps every legal length of a small configuration, which reaches all six table rows, and also the length that is a multiple of 7. Each length is run with all-zero, all-one and pseudo-random data.

- A swapped table entry, or a wrong modulus, gives a start state that does not close the trellis. That shows up as wrong parity, and `tail_ok` stays low.
- A couple split in the wrong order, or a wrong tap, corrupts the systematic or parity bits of individual couples.
- An encoder that skips the length check emits couples for the length that is a multiple of 7.
- Stray first-of-block bytes are driven during encoding. An encoder that accepts them overwrites stored couples or restarts, and its output stream breaks.

// File: rtl/duo_rsc_pkg.sv
package duo_rsc_pkg;

  typedef logic [2:0] trellis_t;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_LOAD = 3'd1,
    PH_CALC = 3'd2,
    PH_ENC  = 3'd3,
    PH_FIN  = 3'd4
  } phase_t;

  // Parity pair {Y, W} for one couple, from the state before the step.
  function automatic logic [1:0] parity_pair(input trellis_t st, input logic a, input logic b);
    logic f;
    f = a ^ b ^ st[2] ^ st[0];
    return {f ^ st[1] ^ st[0], f ^ st[0]};
  endfunction

endpackage

// File: rtl/duo_rsc_step.sv
module duo_rsc_step
  import duo_rsc_pkg::*;
(
  input  trellis_t st,
  input  logic     a,
  input  logic     b,
  output trellis_t nxt
);
  logic fbk;

  always_comb begin
    fbk = a ^ b ^ st[2] ^ st[0];
    nxt = {fbk, st[2] ^ b, st[1] ^ b};
  end
endmodule

// File: rtl/duo_circ_lut.sv
module duo_circ_lut
  import duo_rsc_pkg::*;
(
  input  trellis_t   fin,
  input  logic [2:0] mrem,
  output trellis_t   circ
);
  logic [23:0] row;
  logic [23:0] sh;

  always_comb begin
    unique case (mrem)
      3'd1:    row = {3'd5, 3'd3, 3'd1, 3'd7, 3'd2, 3'd4, 3'd6, 3'd0};
      3'd2:    row = {3'd1, 3'd2, 3'd6, 3'd5, 3'd4, 3'd7, 3'd3, 3'd0};
      3'd3:    row = {3'd4, 3'd1, 3'd7, 3'd2, 3'd6, 3'd3, 3'd5, 3'd0};
      3'd4:    row = {3'd3, 3'd7, 3'd2, 3'd6, 3'd5, 3'd1, 3'd4, 3'd0};
      3'd5:    row = {3'd6, 3'd4, 3'd3, 3'd1, 3'd7, 3'd5, 3'd2, 3'd0};
      3'd6:    row = {3'd2, 3'd5, 3'd4, 3'd3, 3'd1, 3'd6, 3'd7, 3'd0};
      default: row = 24'd0;
    endcase
    sh   = row >> (5'(fin) * 5'd3);
    circ = sh[2:0];
  end
endmodule

// File: rtl/duo_couple_store.sv
module duo_couple_store #(
  parameter int NBYTES = 16,
  parameter int BW     = $clog2(NBYTES),
  parameter int CW     = BW + 2
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [BW-1:0] wr_addr,
  input  logic [7:0]    wr_byte,
  input  logic [CW-1:0] rd_couple,
  output logic          rd_a,
  output logic          rd_b
);
  logic [7:0] mem [NBYTES];
  logic [7:0] rd_byte;
  logic [2:0] pos;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_byte;
  end

  always_comb begin
    rd_byte = mem[rd_couple[CW-1:2]];
    pos     = {rd_couple[1:0], 1'b0};
    rd_a    = rd_byte[3'd7 - pos];
    rd_b    = rd_byte[3'd6 - pos];
  end
endmodule

// File: rtl/circ_duo_rsc_enc.sv
module circ_duo_rsc_enc
  import duo_rsc_pkg::*;
#(
  parameter int MAX_N  = 64,
  parameter int NW     = $clog2(MAX_N + 1),
  localparam int CW     = $clog2(MAX_N),
  localparam int NBYTES = MAX_N / 4,
  localparam int BW     = CW - 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_first,
  input  logic          in_last,
  input  logic [7:0]    in_byte,
  input  logic [NW-1:0] blk_n,
  output logic          busy,
  output logic          out_valid,
  output logic          out_first,
  output logic          out_last,
  output logic          out_a,
  output logic          out_b,
  output logic          out_y,
  output logic          out_w,
  output logic          err_len,
  output logic          tail_ok
);
  // Reset: asserted asynchronously, released through two flops.
  logic [1:0] rsync_q;
  logic       rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_s_n = rsync_q[1];

  phase_t        ph_q, ph_d;
  logic [NW-1:0] n_q, n_d;
  logic [BW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] idx_q, idx_d;
  trellis_t      pre_q, pre_d, st_q, st_d, circ_q, circ_d;
  logic          ov_q, ov_d, of_q, of_d, ol_q, ol_d;
  logic          oa_q, oa_d, ob_q, ob_d, oy_q, oy_d, ow_q, ow_d;
  logic          err_q, err_d, ok_q, ok_d;

  logic          accept, start;
  logic [BW-1:0] wr_addr;
  trellis_t      chain [5];
  trellis_t      enc_nxt, lut_out;
  logic          cur_a, cur_b;
  logic [1:0]    par;
  logic [2:0]    mrem;
  logic          at_last;

  assign start   = in_valid && in_first && (ph_q == PH_IDLE);
  assign accept  = start || (in_valid && (ph_q == PH_LOAD));
  assign wr_addr = start ? '0 : cnt_q;
  assign chain[0] = start ? 3'd0 : pre_q;

  // Zero-state pre-encoding: four trellis steps per byte, MSB couple first.
  for (genvar k = 0; k < 4; k++) begin : g_pre
    duo_rsc_step u_step (
      .st (chain[k]),
      .a  (in_byte[7-2*k]),
      .b  (in_byte[6-2*k]),
      .nxt(chain[k+1])
    );
  end

  duo_couple_store #(.NBYTES(NBYTES), .BW(BW), .CW(CW)) u_store (
    .clk      (clk),
    .wr_en    (accept),
    .wr_addr  (wr_addr),
    .wr_byte  (in_byte),
    .rd_couple(idx_q),
    .rd_a     (cur_a),
    .rd_b     (cur_b)
  );

  duo_rsc_step u_enc_step (.st(st_q), .a(cur_a), .b(cur_b), .nxt(enc_nxt));

  assign mrem = 3'(n_q % 7);
  duo_circ_lut u_lut (.fin(pre_q), .mrem(mrem), .circ(lut_out));

  assign par     = parity_pair(st_q, cur_a, cur_b);
  assign at_last = ({1'b0, idx_q} == (n_q - 1'b1));

  always_comb begin
    ph_d = ph_q;  n_d = n_q;  cnt_d = cnt_q;  idx_d = idx_q;
    pre_d = pre_q;  st_d = st_q;  circ_d = circ_q;
    ov_d = 1'b0;  of_d = 1'b0;  ol_d = 1'b0;
    oa_d = 1'b0;  ob_d = 1'b0;  oy_d = 1'b0;  ow_d = 1'b0;
    err_d = err_q;  ok_d = ok_q;
    if (accept) begin
      pre_d = chain[4];
      cnt_d = wr_addr + 1'b1;
      if (start) begin
        n_d = blk_n;  err_d = 1'b0;  ok_d = 1'b0;
      end
      ph_d = in_last ? PH_CALC : PH_LOAD;
    end
    unique case (ph_q)
      PH_CALC: begin
        if (mrem == 3'd0) begin
          err_d = 1'b1;
          ph_d  = PH_IDLE;
        end else begin
          st_d   = lut_out;
          circ_d = lut_out;
          idx_d  = '0;
          ph_d   = PH_ENC;
        end
      end
      PH_ENC: begin
        ov_d = 1'b1;  oa_d = cur_a;  ob_d = cur_b;
        oy_d = par[1];  ow_d = par[0];
        of_d = (idx_q == '0);
        ol_d = at_last;
        st_d = enc_nxt;
        idx_d = idx_q + 1'b1;
        if (at_last) ph_d = PH_FIN;
      end
      PH_FIN: begin
        ok_d = (st_q == circ_q);
        ph_d = PH_IDLE;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      ph_q <= PH_IDLE;  n_q <= '0;  cnt_q <= '0;  idx_q <= '0;
      pre_q <= '0;  st_q <= '0;  circ_q <= '0;
      ov_q <= 1'b0;  of_q <= 1'b0;  ol_q <= 1'b0;
      oa_q <= 1'b0;  ob_q <= 1'b0;  oy_q <= 1'b0;  ow_q <= 1'b0;
      err_q <= 1'b0;  ok_q <= 1'b0;
    end else begin
      ph_q <= ph_d;  n_q <= n_d;  cnt_q <= cnt_d;  idx_q <= idx_d;
      pre_q <= pre_d;  st_q <= st_d;  circ_q <= circ_d;
      ov_q <= ov_d;  of_q <= of_d;  ol_q <= ol_d;
      oa_q <= oa_d;  ob_q <= ob_d;  oy_q <= oy_d;  ow_q <= ow_d;
      err_q <= err_d;  ok_q <= ok_d;
    end
  end

  assign busy      = (ph_q != PH_IDLE);
  assign out_valid = ov_q;
  assign out_first = of_q;
  assign out_last  = ol_q;
  assign out_a     = oa_q;
  assign out_b     = ob_q;
  assign out_y     = oy_q;
  assign out_w     = ow_q;
  assign err_len   = err_q;
  assign tail_ok   = ok_q;

  // R6: couples only appear while a block is in progress
  a_r6_valid_in_block: assert property (@(posedge clk) disable iff (!rst_s_n)
    ov_q |-> (ph_q != PH_IDLE));
  // R6: the stream opens with its first marker
  a_r6_first_opens: assert property (@(posedge clk) disable iff (!rst_s_n)
    $rose(ov_q) |-> of_q);
  // R6: nothing follows the last couple
  a_r6_last_closes: assert property (@(posedge clk) disable iff (!rst_s_n)
    ol_q |=> !ov_q);
  // R7: a rejected length produces no output
  a_r7_err_silent: assert property (@(posedge clk) disable iff (!rst_s_n)
    err_q |-> !ov_q);
  // R5: a zero final state maps to the zero start state
  a_r5_zero_fixed: assert property (@(posedge clk) disable iff (!rst_s_n)
    (ph_q == PH_CALC && pre_q == 3'd0 && mrem != 3'd0) |=> (st_q == 3'd0));
  // R8: the trellis closes on its start state at the end of every pass
  a_r8_tail_closes: assert property (@(posedge clk) disable iff (!rst_s_n)
    (ph_q == PH_FIN) |=> ok_q);
endmodule

// File: tb/circ_duo_rsc_enc_tb_top.sv
module circ_duo_rsc_enc_tb_top;
  localparam int MAXN = 64;
  localparam int NWB  = $clog2(MAXN + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_first = 1'b0, in_last = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic [NWB-1:0] blk_n = '0;
  logic busy, out_valid, out_first, out_last, out_a, out_b, out_y, out_w, err_len, tail_ok;

  always #2.5 clk = ~clk;

  circ_duo_rsc_enc #(.MAX_N(MAXN)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_first(in_first),
    .in_last(in_last), .in_byte(in_byte), .blk_n(blk_n), .busy(busy),
    .out_valid(out_valid), .out_first(out_first), .out_last(out_last),
    .out_a(out_a), .out_b(out_b), .out_y(out_y), .out_w(out_w),
    .err_len(err_len), .tail_ok(tail_ok)
  );

  int total = 0, bad = 0;
  int cycles = 0;
  int cap_n = 0;
  logic [5:0] cap [0:MAXN-1];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // collect output couples as {first,last,a,b,y,w}
  always @(negedge clk) begin
    if (out_valid) begin
      if (cap_n < MAXN) cap[cap_n] = {out_first, out_last, out_a, out_b, out_y, out_w};
      cap_n++;
    end
  end

  function automatic logic [2:0] tstep(input logic [2:0] s, input logic a, input logic b);
    logic f;
    f = a ^ b ^ s[2] ^ s[0];
    return {f, s[2] ^ b, s[1] ^ b};
  endfunction

  function automatic logic [2:0] tlut(input int m, input logic [2:0] f);
    int r [1:6][0:7] = '{'{0,6,4,2,7,1,3,5}, '{0,3,7,4,5,6,2,1}, '{0,5,3,6,2,7,1,4},
                         '{0,4,1,5,6,2,7,3}, '{0,2,5,7,1,3,4,6}, '{0,7,6,1,3,4,5,2}};
    return 3'(r[m][f]);
  endfunction

  task automatic run_block(input int n, input int pat, input bit poke);
    logic [7:0] data [0:MAXN/4-1];
    logic [5:0] exp [0:MAXN-1];
    logic [2:0] s, c;
    int lcg, w;
    bit err_exp;
    lcg = n * 7 + pat;
    for (int i = 0; i < n/4; i++) begin
      lcg = (lcg * 1103515245 + 12345) & 32'h7fffffff;
      data[i] = (pat == 0) ? 8'h00 : (pat == 1) ? 8'hFF : 8'(lcg >> 11);
    end
    err_exp = (n % 7 == 0);
    s = 3'd0;
    for (int k = 0; k < n; k++)   // R1, R3: zero-start pass
      s = tstep(s, data[k/4][7-2*(k%4)], data[k/4][6-2*(k%4)]);
    c = err_exp ? 3'd0 : tlut(n % 7, s);   // R5
    s = c;
    for (int k = 0; k < n; k++) begin
      logic a, b, f;
      a = data[k/4][7-2*(k%4)];
      b = data[k/4][6-2*(k%4)];
      f = a ^ b ^ s[2] ^ s[0];
      exp[k] = {k == 0, k == n-1, a, b, f ^ s[1] ^ s[0], f ^ s[0]};   // R4
      s = tstep(s, a, b);
    end
    @(negedge clk);
    cap_n = 0;
    for (int i = 0; i < n/4; i++) begin
      in_valid = 1'b1; in_first = (i == 0); in_last = (i == n/4 - 1);
      in_byte = data[i]; blk_n = NWB'(n);
      @(negedge clk);
    end
    in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0;
    if (poke) begin   // R9: stray block starts during encoding
      for (int i = 0; i < 4; i++) begin
        in_valid = 1'b1; in_first = 1'b1; in_last = 1'b1; in_byte = 8'h3C ^ 8'(i);
        blk_n = NWB'(36);
        @(negedge clk);
      end
      in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0;
    end
    w = 0;
    while (busy && w < 1000) begin @(negedge clk); w++; end
    chk(!busy, "R6 block completes", busy, 0);
    if (err_exp) begin
      chk(err_len == 1'b1, "R7 error flag", err_len, 1);
      chk(cap_n == 0, "R7 no output", cap_n, 0);
    end else begin
      chk(err_len == 1'b0, "R7 no error", err_len, 0);
      chk(cap_n == n, "R6 couple count", cap_n, n);
      for (int k = 0; k < n && k < cap_n; k++)
        chk(cap[k] == exp[k], poke ? "R9 R1 R4 couple" : "R1 R4 R6 couple", cap[k], exp[k]);
      chk(tail_ok == 1'b1, "R8 tail closes", tail_ok, 1);
      chk(s == c, "R5 model closes", s, c);
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk(busy == 1'b0 && out_valid == 1'b0 && err_len == 1'b0 && tail_ok == 1'b0,
        "R10 reset state", {busy, out_valid, err_len, tail_ok}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(busy == 1'b0 && out_valid == 1'b0, "R10 after release", {busy, out_valid}, 0);
    for (int n = 32; n <= MAXN; n += 4)   // R2: all legal lengths
      for (int p = 0; p < 3; p++)
        run_block(n, p, (p == 2) && (n % 7 != 0));
    run_block(56, 2, 1'b0);   // R7 again, then
    run_block(44, 2, 1'b0);   // R7 flag clears at next block, R8 set again
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end
endmodule